// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is the slave end of a two-wire serial bus in front of a byte-addressed memory of 4096 or 8192 bytes. It runs on a fast system clock and oversamples the bus clock and data lines through two-flop synchronisers. From the synchronised lines it detects START and STOP conditions, shifts in bytes, and acknowledges by pulling the data line low through an open-drain output enable. It never drives the line high.

A transfer opens with a device byte. The upper nibble of that byte is fixed at 1010. The next three bits must equal the strap inputs, and the lowest bit selects read (1) or write (0). A write carries two word-address bytes, high byte first, and then data bytes. Each data byte goes to an external page-write engine together with its target address. A STOP then tells the engine to program the page it has collected. Reads are served from a combinational memory read port. A read can start at the address that follows the last byte accessed, or it can follow a dummy write that loads the word address and then a repeated START. Reading carries on for as long as the master acknowledges. While the engine reports a programming cycle, the block stays silent on its device address, so the master can poll for completion.

Top module: `twi_mem_slave`

## Requirements
- R1: A START (data falling while clock is high) restarts device-address reception from any state, including the middle of a byte. A STOP (data rising while clock is high) returns the block to idle.
- R2: A device byte of the form 1,0,1,0,s2,s1,s0,rw (MSB first) with s2..s0 equal to `strap` is acknowledged during the ninth clock. Any other device byte gets no acknowledge, and the block then ignores the bus until the next START.
- R3: While `busy_i` is high, the device byte is never acknowledged, for reads and for writes.
- R4: In a write, the first byte after the device byte is the high word-address byte and the second is the low byte. Both are acknowledged. Address bits at or above AW are ignored. Each following data byte is acknowledged and produces one `wr_valid` pulse, with `wr_addr` and `wr_data`.
- R5: Within one write, successive data bytes increment only the low PB (5) address bits, wrapping inside the page. The upper bits stay constant.
- R6: `wr_commit` pulses for one cycle after a STOP that ends a transfer in which at least one data byte was received. A transfer without data, or one that a START cuts short, produces no pulse.
- R7: A random read, meaning a dummy write of the word address followed by a repeated START and a read device byte, returns the byte stored at that word address.
- R8: A read that has no preceding address returns the byte at the last accessed address plus one. The address counter wraps from 2^AW-1 to 0.
- R9: Every byte the master acknowledges is followed by the next byte in sequence. After a master no-acknowledge, the block leaves the line released.
- R10: The block only pulls the data line low. Its output enable rises only while the synchronised bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | When high, the data line is pulled low |
| strap | input | 3 | Pin-strapped device-select bits |
| busy_i | input | 1 | Page-write engine is programming |
| rd_addr | output | AW | Memory read address |
| rd_data | input | 8 | Memory read data for `rd_addr` (combinational) |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | AW | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle strobe that starts page programming |

## Verification
A wrong byte-phase state shows up at the very next ninth clock. The acknowledge is then missing, or it appears where none belongs, for example after a non-matching device byte or while busy is asserted. A corrupted address counter does not show up when it happens. It appears only as a wrong data byte on the next current-address or sequential read, or as a wrong `wr_addr` on the next data strobe. For that reason the tests chain transfers, so that each one depends on the counter left by the one before. An error in the page or top-of-memory wrap is visible only at the byte that crosses the boundary, so the tests place several reads and writes directly across those boundaries.

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int AW = 13,
  parameter int PB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [2:0]    strap,
  input  logic          busy_i,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);
  localparam int HW = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXE, S_ACKO, S_TX, S_ACKI, S_TXW} st_t;
  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DAT} kind_t;

  st_t          st;
  kind_t        kind;
  logic [1:0]   scl_sy, sda_sy;
  logic         scl_q, sda_q;
  logic [2:0]   cnt;
  logic [7:0]   sr;
  logic [HW-1:0] hi;
  logic         rw, oe, wrote;
  logic [AW-1:0] addr;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire dev_hit   = (sr[7:4] == 4'b1010) && (sr[3:1] == strap) && !busy_i;

  logic [PB-1:0] page_lo;
  assign page_lo = addr[PB-1:0] + 1'b1;

  assign sda_oe  = oe;
  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_DEV;
      cnt       <= '0;
      sr        <= '0;
      hi        <= '0;
      rw        <= 1'b0;
      addr      <= '0;
      oe        <= 1'b0;
      wrote     <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_det) begin
        st    <= S_RX;
        kind  <= K_DEV;
        cnt   <= '0;
        oe    <= 1'b0;
        wrote <= 1'b0;
      end else if (stop_det) begin
        st        <= S_IDLE;
        oe        <= 1'b0;
        wr_commit <= wrote;
        wrote     <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= S_RXE;
          end
          S_RXE: if (scl_fall) begin
            case (kind)
              K_DEV: if (dev_hit) begin
                rw <= sr[0];
                oe <= 1'b1;
                st <= S_ACKO;
              end else begin
                st <= S_IDLE;
              end
              K_AHI: begin
                hi <= sr[HW-1:0];
                oe <= 1'b1;
                st <= S_ACKO;
              end
              K_ALO: begin
                addr <= {hi, sr};
                oe   <= 1'b1;
                st   <= S_ACKO;
              end
              default: begin
                wr_valid <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= sr;
                addr     <= {addr[AW-1:PB], page_lo};
                wrote    <= 1'b1;
                oe       <= 1'b1;
                st       <= S_ACKO;
              end
            endcase
          end
          S_ACKO: if (scl_fall) begin
            cnt <= '0;
            if (kind == K_DEV && rw) begin
              sr <= rd_data;
              oe <= ~rd_data[7];
              st <= S_TX;
            end else begin
              oe <= 1'b0;
              st <= S_RX;
              case (kind)
                K_DEV:   kind <= K_AHI;
                K_AHI:   kind <= K_ALO;
                default: kind <= K_DAT;
              endcase
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              oe   <= 1'b0;
              st   <= S_ACKI;
              addr <= addr + 1'b1;
            end else begin
              cnt <= cnt + 3'd1;
              sr  <= {sr[6:0], 1'b0};
              oe  <= ~sr[6];
            end
          end
          S_ACKI: if (scl_rise) st <= sda_s ? S_IDLE : S_TXW;
          S_TXW: if (scl_fall) begin
            sr  <= rd_data;
            oe  <= ~rd_data[7];
            cnt <= '0;
            st  <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end

  logic [PB-1:0] wr_lo_next;
  assign wr_lo_next = wr_addr[PB-1:0] + 1'b1;

  a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> st == S_IDLE);

  a_r3_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe) && st == S_ACKO && kind == K_DEV) |-> !$past(busy_i));

  a_r5_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (addr[AW-1:PB] == wr_addr[AW-1:PB]) && (addr[PB-1:0] == wr_lo_next));

  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_det));

  a_r8_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKI && $past(st) == S_TX) |-> addr == AW'($past(addr) + 1'b1));

  a_r10_pull_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_s);
endmodule

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, wr_valid, wr_commit;
  logic [12:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mf(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction
  assign rd_data = mf(rd_addr);

  twi_mem_slave #(.AW(13), .PB(5)) i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .busy_i(busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit));

  int total = 0, bad = 0, ncommit = 0, nw = 0, r10_viol = 0;
  logic [12:0] la [16];
  logic [7:0]  ld [16];
  logic prev_oe = 1'b0;
  logic watch_low = 1'b0;

  always @(negedge clk) begin
    if (wr_commit) ncommit++;
    if (wr_valid && nw < 16) begin la[nw] = wr_addr; ld[nw] = wr_data; nw++; end
    if (sda_oe && !prev_oe && scl) r10_viol++;
    if (sda_oe) watch_low = 1'b1;
    prev_oe = sda_oe;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(); scl = 1'b1; w(); sda_m = 1'b0; w(); scl = 1'b0; w();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(); scl = 1'b1; w(); sda_m = 1'b1; w();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(); scl = 1'b1; w(); scl = 1'b0; w();
    end
    sda_m = 1'b1; w(); scl = 1'b1; w(); ack = ~sda_line; scl = 1'b0; w();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(); scl = 1'b1; w(); b[i] = sda_line; scl = 1'b0;
    end
    w(); sda_m = ~mack; w(); scl = 1'b1; w(); scl = 1'b0; w(); sda_m = 1'b1;
  endtask

  localparam logic [19:0] TBL [6] = '{
    {16'h0010, 4'd1}, {16'h0ABC, 4'd3}, {16'hE005, 4'd2},
    {16'h1FFE, 4'd4}, {16'h101F, 4'd2}, {16'h0000, 4'd1}};

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    w();
    // R10 reset state
    chk(!sda_oe && !wr_valid && !wr_commit, "R10 reset", sda_oe, 0);

    // R2 R4 R5 R6 page write with ignored upper bits and page wrap
    bus_start();
    send_byte(8'hAA, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'hF3, ack); chk(ack, "R4 addr hi ack", ack, 1);
    send_byte(8'h1E, ack); chk(ack, "R4 addr lo ack", ack, 1);
    send_byte(8'h11, ack); chk(ack, "R4 data ack", ack, 1);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    bus_stop(); w();
    chk(nw == 3, "R4 strobe count", nw, 3);
    chk(la[0] == 13'h131E && ld[0] == 8'h11, "R4 first byte", la[0], 13'h131E);
    chk(la[1] == 13'h131F && ld[1] == 8'h22, "R5 second byte", la[1], 13'h131F);
    chk(la[2] == 13'h1300 && ld[2] == 8'h33, "R5 page wrap", la[2], 13'h1300);
    chk(ncommit == 1, "R6 commit after stop", ncommit, 1);

    // R3 busy: no ack
    busy = 1'b1;
    bus_start();
    send_byte(8'hAA, ack); chk(!ack, "R3 busy no ack", ack, 0);
    bus_stop();
    busy = 1'b0; w();

    // R8 current address after write
    bus_start();
    send_byte(8'hAB, ack); chk(ack, "R8 read device ack", ack, 1);
    recv_byte(1'b0, b); bus_stop();
    chk(b == mf(13'h1301), "R8 current after write", b, mf(13'h1301));

    // R2 mismatch ignored until next START
    bus_start();
    send_byte(8'hA2, ack); chk(!ack, "R2 mismatch no ack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();

    // R7 R9 R8 random and sequential reads
    c0 = ncommit;
    for (int k = 0; k < 6; k++) begin
      logic [15:0] wa;
      int n;
      wa = TBL[k][19:4];
      n = int'(TBL[k][3:0]);
      bus_start();
      send_byte(8'hAA, ack);
      send_byte(wa[15:8], ack);
      send_byte(wa[7:0], ack);
      bus_start();
      send_byte(8'hAB, ack); chk(ack, "R7 read ack", ack, 1);
      for (int i = 0; i < n; i++) begin
        logic [12:0] ea;
        ea = wa[12:0] + 13'(i);
        recv_byte(i != n - 1, b);
        chk(b == mf(ea), "R7 R9 sequential data", b, mf(ea));
      end
      bus_stop();
    end
    chk(ncommit == c0, "R6 no commit without data", ncommit, c0);

    // R1 START mid-byte aborts; current address unchanged (0x0001)
    bus_start();
    send_byte(8'hAA, ack);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b0; w(); scl = 1'b1; w(); scl = 1'b0; w();
    end
    bus_start();
    send_byte(8'hAB, ack); chk(ack, "R1 restart ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == mf(13'h0001), "R1 abort keeps address", b, mf(13'h0001));

    // R9 line stays released after master nack
    watch_low = 1'b0;
    for (int i = 0; i < 9; i++) begin
      w(); scl = 1'b1; w(); scl = 1'b0;
    end
    w();
    chk(!watch_low, "R9 released after nack", watch_low, 0);
    bus_stop();
    chk(r10_viol == 0, "R10 pull only with clock low", r10_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule